// File: doc/BRIEF.md
# AC97 Link Bit-Clock Watchdog and Warm Wake Controller

This block lives on the controller end of an AC97 serial link. The codec supplies the bit clock. The block synchronizes that clock into the system-clock domain and times how long it has gone without an edge. Once the bit clock has been quiet long enough, a status flag rises. A little later the outgoing SYNC and serial-data lines are clamped low, so the stopped link is not driven with stale frame data.

To wake a sleeping codec, software strobes a warm-reset request. The request is honoured only when the bit clock has been silent for at least one audio frame, measured in system clocks. When honoured, SYNC is held high for a fixed, parameterised number of system clocks. The pulse always runs to its full length, even if the codec restarts its clock part way through. From that moment a power-up-in-progress bit reads as 1. Once the bit clock is running again, each frame-start strobe advances a 3-bit counter that saturates at 4. Power-up ends when the counter reaches 4. The counter drops back to 0 whenever the idle condition is detected.

While the link is running and no wake pulse is active, the normal SYNC and serial-data requests from the frame generator pass straight through.

Top module: `ac97_link_wake`

## Requirements
- R1: The idle flag `bclk_idle_o` rises after IDLE_FLAG_CYC system clocks (default 48) without a synchronized bit-clock edge. It falls within a few cycles of the bit clock toggling again.
- R2: After FORCE_CYC system clocks (default 66) without a bit-clock edge, `sdata_o` is 0 and `sync_o` is 0, unless a wake pulse is active.
- R3: A wake request accepted while the bit clock has been idle for at least FRAME_IDLE_CYC system clocks drives `sync_o` high from the next cycle for exactly WAKE_CYC system clocks (default 60, which is 1.2 µs at 50 MHz).
- R4: A wake request made while the bit clock has had an edge within the last FRAME_IDLE_CYC system clocks is ignored. `sync_o` is not raised and `pwrup_busy_o` does not change.
- R5: The wake pulse keeps its full WAKE_CYC length when the bit clock restarts during the pulse.
- R6: `pwrup_busy_o` reads 1 from the cycle after a wake request is accepted until the frame counter has reached 4.
- R7: Each `frame_tick_i` strobe seen while the idle flag is low advances `frame_cnt_o` by one. The counter saturates at 4.
- R8: `frame_cnt_o` returns to 0 in the cycle after the idle flag is seen set.
- R9: After reset, the idle flag is 1, both link outputs are 0, the counter is 0 and `pwrup_busy_o` is 0.
- R10: While the bit clock is active and no wake pulse runs, `sync_o` equals `sync_req_i` and `sdata_o` equals `sdata_req_i`.
- R11: `frame_cnt_o` never takes a value from 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Codec bit clock, asynchronous to clk_i |
| frame_tick_i | input | 1 | One-cycle strobe at each audio frame start |
| sync_req_i | input | 1 | SYNC value requested by the frame generator |
| sdata_req_i | input | 1 | Serial data value requested by the frame generator |
| wake_req_i | input | 1 | One-cycle strobe asking for a warm wake |
| sync_o | output | 1 | SYNC line to the codec |
| sdata_o | output | 1 | Serial data line to the codec |
| bclk_idle_o | output | 1 | Bit clock seen idle |
| pwrup_busy_o | output | 1 | Power-up in progress |
| frame_cnt_o | output | 3 | Frames since bit-clock restart, saturating at 4 |

## Verification
The bench stops the bit clock and samples the idle flag and the clamp a few cycles either side of their thresholds. A watchdog with an off-by-many error fails one side of that window. Wake requests are placed in three spots: while the clock runs, after the idle flag but before a full frame of silence, and after a full frame. A design that accepts too early gives a stray SYNC pulse. The clock is restarted in the middle of a wake pulse and the high cycles are counted, so a pulse that aborts on restart is caught. Random runs of frame strobes check the saturation at 4, the clear on idle, and the release of the power-up bit, against a bench model.

// File: rtl/ac97lw_pkg.sv
package ac97lw_pkg;

  localparam logic [2:0] FRAME_SAT = 3'd4;

  // next value of the post-wake frame counter
  function automatic logic [2:0] frame_next(input logic [2:0] cur,
                                            input logic       tick,
                                            input logic       clr);
    logic [2:0] nxt;
    nxt = cur;
    if (clr)
      nxt = 3'd0;
    else if (tick && (cur < FRAME_SAT))
      nxt = cur + 3'd1;
    return nxt;
  endfunction

  // largest of three thresholds, used to size the idle timer
  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ac97lw_bclk_mon.sv
module ac97lw_bclk_mon #(
  parameter int unsigned IDLE_FLAG_CYC  = 48,
  parameter int unsigned FORCE_CYC      = 66,
  parameter int unsigned FRAME_IDLE_CYC = 1042
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  output logic bclk_edge_o,
  output logic idle_flag_o,
  output logic force_low_o,
  output logic frame_idle_o
);
  import ac97lw_pkg::*;

  localparam int unsigned TMAX = max3(IDLE_FLAG_CYC, FORCE_CYC, FRAME_IDLE_CYC);
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] TMAX_V  = TW'(TMAX);
  localparam logic [TW-1:0] IDLE_V  = TW'(IDLE_FLAG_CYC);
  localparam logic [TW-1:0] FORCE_V = TW'(FORCE_CYC);
  localparam logic [TW-1:0] FRAME_V = TW'(FRAME_IDLE_CYC);

  logic [2:0]    sync_q;
  logic [TW-1:0] quiet_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], bclk_i};
  end

  assign bclk_edge_o = sync_q[2] ^ sync_q[1];

  // quiet timer: reset starts it saturated, so the link reads idle
  always_ff @(posedge clk_i) begin
    if (!rst_ni)             quiet_q <= TMAX_V;
    else if (bclk_edge_o)    quiet_q <= '0;
    else if (quiet_q != TMAX_V) quiet_q <= quiet_q + 1'b1;
  end

  assign idle_flag_o  = (quiet_q >= IDLE_V);
  assign force_low_o  = (quiet_q >= FORCE_V);
  assign frame_idle_o = (quiet_q >= FRAME_V);

  a_r1_edge_clears_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_edge_o |=> !idle_flag_o);
  a_r2_force_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_o |-> idle_flag_o);
  a_r4_frame_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_idle_o |-> idle_flag_o);

endmodule

// File: rtl/ac97lw_wake_gen.sv
module ac97lw_wake_gen #(
  parameter int unsigned WAKE_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_req_i,
  input  logic frame_idle_i,
  output logic accept_o,
  output logic sync_hi_o
);
  localparam int unsigned WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] WAKE_V = WW'(WAKE_CYC);

  logic [WW-1:0] left_q;

  assign sync_hi_o = (left_q != '0);
  assign accept_o  = wake_req_i && frame_idle_i && !sync_hi_o;

  // counts down independently of the bit clock, so a restart never cuts it short
  always_ff @(posedge clk_i) begin
    if (!rst_ni)        left_q <= '0;
    else if (accept_o)  left_q <= WAKE_V;
    else if (sync_hi_o) left_q <= left_q - 1'b1;
  end

  a_r3_pulse_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> sync_hi_o);
  a_r4_no_pulse_when_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_req_i && !frame_idle_i && !sync_hi_o) |=> !sync_hi_o);
  a_r5_pulse_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_hi_o && left_q > 1) |=> sync_hi_o);

endmodule

// File: rtl/ac97lw_frame_cnt.sv
module ac97lw_frame_cnt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       clr_i,
  output logic [2:0] cnt_o
);
  import ac97lw_pkg::*;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= frame_next(cnt_o, tick_i, clr_i);
  end

  a_r11_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= FRAME_SAT);
  a_r7_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == FRAME_SAT && !clr_i) |=> cnt_o == FRAME_SAT);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == 3'd0);

endmodule

// File: rtl/ac97_link_wake.sv
module ac97_link_wake #(
  parameter int unsigned IDLE_FLAG_CYC  = 48,
  parameter int unsigned FORCE_CYC      = 66,
  parameter int unsigned FRAME_IDLE_CYC = 1042,
  parameter int unsigned WAKE_CYC       = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bclk_i,
  input  logic       frame_tick_i,
  input  logic       sync_req_i,
  input  logic       sdata_req_i,
  input  logic       wake_req_i,
  output logic       sync_o,
  output logic       sdata_o,
  output logic       bclk_idle_o,
  output logic       pwrup_busy_o,
  output logic [2:0] frame_cnt_o
);
  import ac97lw_pkg::*;

  logic bclk_edge, idle_flag, force_low, frame_idle;
  logic wake_accept, wake_hi;
  logic pwrup_q;

  ac97lw_bclk_mon #(
    .IDLE_FLAG_CYC (IDLE_FLAG_CYC),
    .FORCE_CYC     (FORCE_CYC),
    .FRAME_IDLE_CYC(FRAME_IDLE_CYC)
  ) u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bclk_i      (bclk_i),
    .bclk_edge_o (bclk_edge),
    .idle_flag_o (idle_flag),
    .force_low_o (force_low),
    .frame_idle_o(frame_idle)
  );

  ac97lw_wake_gen #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_req_i  (wake_req_i),
    .frame_idle_i(frame_idle),
    .accept_o    (wake_accept),
    .sync_hi_o   (wake_hi)
  );

  ac97lw_frame_cnt u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(frame_tick_i && !idle_flag),
    .clr_i (idle_flag),
    .cnt_o (frame_cnt_o)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                         pwrup_q <= 1'b0;
    else if (wake_accept)                pwrup_q <= 1'b1;
    else if (frame_cnt_o == FRAME_SAT)   pwrup_q <= 1'b0;
  end

  assign sync_o       = wake_hi ? 1'b1 : (force_low ? 1'b0 : sync_req_i);
  assign sdata_o      = force_low ? 1'b0 : sdata_req_i;
  assign bclk_idle_o  = idle_flag;
  assign pwrup_busy_o = pwrup_q;

  a_r2_clamp_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low |-> !sdata_o);
  a_r6_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_accept |=> pwrup_busy_o);
  a_r6_busy_until_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrup_busy_o && frame_cnt_o != FRAME_SAT) |=> pwrup_busy_o);

endmodule

// File: tb/ac97_link_wake_tb.sv
module ac97_link_wake_tb;
  localparam int IDLE_C  = 48;
  localparam int FORCE_C = 66;
  localparam int FRAME_C = 1042;
  localparam int WAKE_C  = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, bclk_run = 1'b0;
  logic tick = 1'b0, sreq = 1'b0, dreq = 1'b0, wreq = 1'b0;
  logic sync_w, sdata_w, idle_w, busy_w;
  logic [2:0] cnt_w;

  int errs = 0, checks = 0;
  int model_cnt = 0;

  always #10 clk = ~clk;

  ac97_link_wake #(
    .IDLE_FLAG_CYC(IDLE_C), .FORCE_CYC(FORCE_C),
    .FRAME_IDLE_CYC(FRAME_C), .WAKE_CYC(WAKE_C)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .frame_tick_i(tick),
    .sync_req_i(sreq), .sdata_req_i(dreq), .wake_req_i(wreq),
    .sync_o(sync_w), .sdata_o(sdata_w), .bclk_idle_o(idle_w),
    .pwrup_busy_o(busy_w), .frame_cnt_o(cnt_w)
  );

  always @(negedge clk) if (bclk_run) bclk <= ~bclk;

  function automatic int sat4(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame_pulse();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    model_cnt = sat4(model_cnt + 1);
  endtask

  task automatic wake_strobe();
    wreq = 1'b1; @(negedge clk); wreq = 1'b0;
  endtask

  // count consecutive high samples of sync_o, starting at the current negedge
  task automatic count_high(input int restart_at, output int n);
    n = 0;
    while (sync_w === 1'b1 && n < 4 * WAKE_C) begin
      n++;
      if (n == restart_at) bclk_run = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int gap;
    void'($urandom(32'h5eed_ac97));
    cyc(3);
    rst_n = 1'b1;
    sreq = 1'b1; dreq = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 idle", idle_w, 1);
    chk("R9 sync", sync_w, 0);
    chk("R9 sdata", sdata_w, 0);
    chk("R9 cnt", cnt_w, 0);
    chk("R9 busy", busy_w, 0);
    sreq = 1'b0; dreq = 1'b0;

    // R3/R5: wake from reset idle, restart bit clock mid-pulse
    wake_strobe();
    chk("R6 busy after accept", busy_w, 1);
    count_high(10, n);
    chk("R3/R5 pulse length", n, WAKE_C);
    cyc(8);
    chk("R1 idle clears after restart", idle_w, 0);
    chk("R8 cnt still 0", cnt_w, 0);
    model_cnt = 0;

    // R7 counting with random gaps, R6 busy release
    for (int i = 0; i < 7; i++) begin
      gap = 1 + ($urandom % 20);
      cyc(gap);
      frame_pulse();
      chk("R7 count", cnt_w, model_cnt);
      chk("R11 range", (cnt_w <= 4) ? 1 : 0, 1);
      if (i == 2) chk("R6 busy before four", busy_w, 1);
    end
    cyc(2);
    chk("R6 busy released", busy_w, 0);

    // R10 pass-through with random requests
    for (int i = 0; i < 20; i++) begin
      sreq = 1'($urandom); dreq = 1'($urandom);
      @(negedge clk);
      chk("R10 sync", sync_w, sreq);
      chk("R10 sdata", sdata_w, dreq);
    end

    // R4 wake while bit clock running
    sreq = 1'b0;
    wake_strobe();
    for (int i = 0; i < 5; i++) begin
      chk("R4 ignored live sync", sync_w, 0);
      @(negedge clk);
    end
    chk("R4 busy unchanged", busy_w, 0);

    // R1/R2/R8: stop the bit clock
    dreq = 1'b1; sreq = 1'b1;
    bclk_run = 1'b0;
    cyc(IDLE_C - 4);
    chk("R1 idle not yet", idle_w, 0);
    chk("R8 cnt before idle", cnt_w, 4);
    cyc(10);
    chk("R1 idle set", idle_w, 1);
    chk("R8 cnt cleared", cnt_w, 0);
    chk("R2 not yet forced", sdata_w, 1);
    cyc(FORCE_C - IDLE_C - 6);
    chk("R2 still passes", sdata_w, 1);
    cyc(10);
    chk("R2 sdata forced", sdata_w, 0);
    chk("R2 sync forced", sync_w, 0);
    model_cnt = 0;

    // R4: frame ticks while idle must not count; early wake ignored
    frame_pulse();
    chk("R7 no count while idle", cnt_w, 0);
    model_cnt = 0;
    wake_strobe();
    for (int i = 0; i < 5; i++) begin
      chk("R4 early wake ignored", sync_w, 0);
      @(negedge clk);
    end
    chk("R4 early busy", busy_w, 0);

    // R3: accepted after a full frame of silence
    cyc(FRAME_C + 10);
    wake_strobe();
    count_high(0, n);
    chk("R3 pulse after frame", n, WAKE_C);
    chk("R6 busy while dead", busy_w, 1);
    chk("R2 sync low after pulse", sync_w, 0);

    // random restart/stop cycles
    for (int r = 0; r < 4; r++) begin
      bclk_run = 1'b1; cyc(8); model_cnt = 0;
      for (int k = 0; k < 1 + ($urandom % 6); k++) begin
        cyc(1 + ($urandom % 10));
        frame_pulse();
        chk("R7 random count", cnt_w, model_cnt);
      end
      bclk_run = 1'b0;
      cyc(IDLE_C + 8);
      chk("R8 random clear", cnt_w, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule